// File: doc/BRIEF.md
# Serial ADC Readout Controller

This block sits on the host side of a point-to-point serial link to a sampling analog-to-digital converter. It reads one conversion at a time. A start request drops the chip-select line, which makes the converter sample and begin converting. The block then clocks out one frame on a serial clock that idles high. It captures the data line on each rising clock edge and throws away the four zero bits that lead every frame. It presents the remaining 12, 10 or 8 result bits as a right-aligned unsigned word, together with a one-cycle valid strobe.

The serial clock is the system clock divided by an even ratio, so its high and low phases are equal. After chip-select is released, the block holds off the next conversion for a programmable acquisition interval, which gives the converter input time to settle. The block latches the divider, the acquisition length and the resolution when it accepts a start. If a bit that should be a leading zero reads as one, the block raises a protocol-error flag.

Top module: `adc_rdout_ctl`

## Requirements
- R1: While reset is asserted, the outputs are as follows: cs_n high, sclk high, valid low, busy low, proto_err low and data_out zero.
- R2: sclk is high whenever cs_n is high (clock polarity 1). A frame runs as follows, with H = cfg_half and H = 0 treated as 1. cs_n falls and sclk stays high for H cycles. Then 4+N bit periods follow, each with sclk low for H cycles and then high for H cycles, giving a divide ratio of 2H. miso is sampled on each sclk rising edge.
- R3: The first four sampled bits are discarded. The next N bits form the result, most significant bit first. The result appears on data_out right-aligned, and the unused upper bits are zero.
- R4: res_sel selects N as follows: 2'b00 gives 12, 2'b01 gives 10, and 2'b10 or 2'b11 gives 8.
- R5: cs_n rises H cycles after the last sclk rising edge. valid is high for exactly that one cycle. data_out holds its value until the next valid pulse.
- R6: After cs_n rises, busy stays high for cfg_acq+1 cycles. The next cs_n falling edge therefore comes at least cfg_acq+1 cycles after the previous rising edge.
- R7: A start request is accepted only when busy is low. A request while busy is high has no effect on cs_n, sclk or the frame in progress.
- R8: proto_err goes high if any of the four leading bits reads as one. It is high no later than the valid pulse of that frame. It stays high until the next accepted start clears it.
- R9: cfg_half, cfg_acq and res_sel are latched when a start is accepted. Changing them during a frame does not affect that frame or its acquisition interval.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| start | input | 1 | Conversion request, accepted when the block is not busy |
| res_sel | input | 2 | Resolution select: 00 gives 12 bits, 01 gives 10 bits, 10 or 11 gives 8 bits |
| cfg_half | input | DIV_W | Serial clock half period in system cycles (0 acts as 1) |
| cfg_acq | input | ACQ_W | Extra acquisition cycles held off after chip-select is released |
| miso | input | 1 | Serial data from the converter |
| cs_n | output | 1 | Active-low chip select |
| sclk | output | 1 | Serial clock, idles high |
| data_out | output | DATA_W | Right-aligned unsigned result |
| valid | output | 1 | One-cycle strobe when data_out updates |
| busy | output | 1 | High during a frame and its acquisition interval |
| proto_err | output | 1 | A leading bit read as one in the last frame |

## Verification
A bad half-period count or a bad bit counter shows up at once as a misplaced sclk edge, or as a cs_n rising edge in the wrong cycle, because the bench predicts every output in every cycle. A bad acquisition counter shows up as a busy falling edge one or more cycles off, and so does a start that is wrongly accepted. A bad shift path or prefix handling shows up at the next valid pulse, as a wrong data_out word or a wrong proto_err level, within one frame of 4+N bit periods.

// File: rtl/adc_rdout_pkg.sv
package adc_rdout_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LEAD,
    ST_SHIFT,
    ST_TAIL,
    ST_ACQ
  } seq_st_t;

  // Number of payload bits for a resolution select value
  function automatic int unsigned payload_bits(input logic [1:0] sel,
                                               input int unsigned full);
    case (sel)
      2'b00:   return full;
      2'b01:   return full - 2;
      default: return full - 4;
    endcase
  endfunction

endpackage

// File: rtl/adc_rdout_rst_sync.sv
module adc_rdout_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n_a,
  output logic rst_n_s
);

  logic [STAGES-1:0] sr_q;

  always_ff @(posedge clk or negedge rst_n_a) begin
    if (!rst_n_a) sr_q <= '0;
    else          sr_q <= {sr_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_s = sr_q[STAGES-1];

endmodule

// File: rtl/adc_rdout_seq.sv
module adc_rdout_seq
  import adc_rdout_pkg::*;
#(
  parameter int DATA_W = 12,
  parameter int PRE_W  = 4,
  parameter int DIV_W  = 8,
  parameter int ACQ_W  = 16,
  localparam int CNT_W = $clog2(PRE_W + DATA_W + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [1:0]       res_sel,
  input  logic [DIV_W-1:0] cfg_half,
  input  logic [ACQ_W-1:0] cfg_acq,
  output logic             cs_n,
  output logic             sclk,
  output logic             busy,
  output logic             frame_start,
  output logic             sample_en,
  output logic             in_prefix,
  output logic             frame_done
);

  seq_st_t          state_q, state_d;
  logic [DIV_W-1:0] hc_q, hc_d;
  logic [DIV_W-1:0] half_q, half_d;
  logic [ACQ_W-1:0] acq_q, acq_d;
  logic [ACQ_W-1:0] acnt_q, acnt_d;
  logic [CNT_W-1:0] bit_q, bit_d;
  logic [CNT_W-1:0] len_q, len_d;
  logic             cs_q, cs_d;
  logic             sclk_q, sclk_d;

  always_comb begin
    state_d     = state_q;
    hc_d        = hc_q;
    half_d      = half_q;
    acq_d       = acq_q;
    acnt_d      = acnt_q;
    bit_d       = bit_q;
    len_d       = len_q;
    cs_d        = cs_q;
    sclk_d      = sclk_q;
    frame_start = 1'b0;
    sample_en   = 1'b0;
    frame_done  = 1'b0;
    case (state_q)
      ST_IDLE: begin
        if (start) begin
          frame_start = 1'b1;
          half_d  = (cfg_half == '0) ? DIV_W'(1) : cfg_half;
          acq_d   = cfg_acq;
          len_d   = CNT_W'(PRE_W + payload_bits(res_sel, DATA_W));
          hc_d    = half_d - 1'b1;
          bit_d   = '0;
          cs_d    = 1'b0;
          state_d = ST_LEAD;
        end
      end
      ST_LEAD: begin
        if (hc_q == '0) begin
          sclk_d  = 1'b0;
          hc_d    = half_q - 1'b1;
          state_d = ST_SHIFT;
        end else begin
          hc_d = hc_q - 1'b1;
        end
      end
      ST_SHIFT: begin
        if (hc_q == '0) begin
          hc_d = half_q - 1'b1;
          if (!sclk_q) begin
            sclk_d    = 1'b1;
            sample_en = 1'b1;
            bit_d     = bit_q + 1'b1;
            if (bit_q == len_q - 1'b1) state_d = ST_TAIL;
          end else begin
            sclk_d = 1'b0;
          end
        end else begin
          hc_d = hc_q - 1'b1;
        end
      end
      ST_TAIL: begin
        if (hc_q == '0) begin
          cs_d       = 1'b1;
          frame_done = 1'b1;
          acnt_d     = acq_q;
          state_d    = ST_ACQ;
        end else begin
          hc_d = hc_q - 1'b1;
        end
      end
      ST_ACQ: begin
        if (acnt_q == '0) state_d = ST_IDLE;
        else              acnt_d  = acnt_q - 1'b1;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      hc_q    <= '0;
      half_q  <= DIV_W'(1);
      acq_q   <= '0;
      acnt_q  <= '0;
      bit_q   <= '0;
      len_q   <= '0;
      cs_q    <= 1'b1;
      sclk_q  <= 1'b1;
    end else begin
      state_q <= state_d;
      hc_q    <= hc_d;
      half_q  <= half_d;
      acq_q   <= acq_d;
      acnt_q  <= acnt_d;
      bit_q   <= bit_d;
      len_q   <= len_d;
      cs_q    <= cs_d;
      sclk_q  <= sclk_d;
    end
  end

  assign cs_n      = cs_q;
  assign sclk      = sclk_q;
  assign busy      = (state_q != ST_IDLE);
  assign in_prefix = (bit_q < CNT_W'(PRE_W));

endmodule

// File: rtl/adc_rdout_shift.sv
module adc_rdout_shift #(
  parameter int DATA_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frame_start,
  input  logic              sample_en,
  input  logic              in_prefix,
  input  logic              frame_done,
  input  logic              miso,
  output logic [DATA_W-1:0] data_out,
  output logic              valid,
  output logic              proto_err
);

  logic [DATA_W-1:0] sh_q, sh_d;
  logic [DATA_W-1:0] dat_q, dat_d;
  logic              vld_q, vld_d;
  logic              err_q, err_d;

  always_comb begin
    sh_d  = sh_q;
    dat_d = dat_q;
    err_d = err_q;
    vld_d = frame_done;
    if (frame_start) begin
      sh_d  = '0;
      err_d = 1'b0;
    end else if (sample_en) begin
      if (in_prefix) begin
        if (miso) err_d = 1'b1;
      end else begin
        sh_d = {sh_q[DATA_W-2:0], miso};
      end
    end
    if (frame_done) dat_d = sh_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q  <= '0;
      dat_q <= '0;
      vld_q <= 1'b0;
      err_q <= 1'b0;
    end else begin
      sh_q  <= sh_d;
      dat_q <= dat_d;
      vld_q <= vld_d;
      err_q <= err_d;
    end
  end

  assign data_out  = dat_q;
  assign valid     = vld_q;
  assign proto_err = err_q;

endmodule

// File: rtl/adc_rdout_ctl.sv
module adc_rdout_ctl #(
  parameter int DATA_W = 12,
  parameter int PRE_W  = 4,
  parameter int DIV_W  = 8,
  parameter int ACQ_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [1:0]        res_sel,
  input  logic [DIV_W-1:0]  cfg_half,
  input  logic [ACQ_W-1:0]  cfg_acq,
  input  logic              miso,
  output logic              cs_n,
  output logic              sclk,
  output logic [DATA_W-1:0] data_out,
  output logic              valid,
  output logic              busy,
  output logic              proto_err
);

  logic rst_n_s;
  logic frame_start;
  logic sample_en;
  logic in_prefix;
  logic frame_done;

  adc_rdout_rst_sync #(.STAGES(2)) u_rst (
    .clk     (clk),
    .rst_n_a (rst_n),
    .rst_n_s (rst_n_s)
  );

  adc_rdout_seq #(
    .DATA_W (DATA_W),
    .PRE_W  (PRE_W),
    .DIV_W  (DIV_W),
    .ACQ_W  (ACQ_W)
  ) u_seq (
    .clk         (clk),
    .rst_n       (rst_n_s),
    .start       (start),
    .res_sel     (res_sel),
    .cfg_half    (cfg_half),
    .cfg_acq     (cfg_acq),
    .cs_n        (cs_n),
    .sclk        (sclk),
    .busy        (busy),
    .frame_start (frame_start),
    .sample_en   (sample_en),
    .in_prefix   (in_prefix),
    .frame_done  (frame_done)
  );

  adc_rdout_shift #(.DATA_W(DATA_W)) u_shift (
    .clk         (clk),
    .rst_n       (rst_n_s),
    .frame_start (frame_start),
    .sample_en   (sample_en),
    .in_prefix   (in_prefix),
    .frame_done  (frame_done),
    .miso        (miso),
    .data_out    (data_out),
    .valid       (valid),
    .proto_err   (proto_err)
  );

endmodule

// File: rtl/adc_rdout_chk.sv
module adc_rdout_chk (
  input logic clk,
  input logic rst_n,
  input logic start,
  input logic cs_n,
  input logic sclk,
  input logic valid,
  input logic busy,
  input logic proto_err
);

  // R2
  sclk_idle_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |-> sclk);

  // R5
  valid_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    valid |=> !valid);

  // R5
  valid_at_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    valid |-> $rose(cs_n));

  // R6
  busy_after_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cs_n) |-> busy);

  // R7
  start_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cs_n) |-> $past(start && !busy));

  // R7
  idle_cs_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> cs_n);

  // R8
  err_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !start) |=> $stable(proto_err));

endmodule

bind adc_rdout_ctl adc_rdout_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .start     (start),
  .cs_n      (cs_n),
  .sclk      (sclk),
  .valid     (valid),
  .busy      (busy),
  .proto_err (proto_err)
);

// File: tb/sim_adc_rdout_ctl.sv
`timescale 1ns/100ps
module sim_adc_rdout_ctl;

  localparam int DATA_W = 12;
  localparam int DIV_W  = 8;
  localparam int ACQ_W  = 16;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              start = 1'b0;
  logic [1:0]        res_sel = 2'b00;
  logic [DIV_W-1:0]  cfg_half = 8'd1;
  logic [ACQ_W-1:0]  cfg_acq = '0;
  logic              miso = 1'b0;
  logic              cs_n, sclk, valid, busy, proto_err;
  logic [DATA_W-1:0] data_out;

  always #2.5 clk = ~clk;

  adc_rdout_ctl u0 (
    .clk (clk), .rst_n (rst_n), .start (start), .res_sel (res_sel),
    .cfg_half (cfg_half), .cfg_acq (cfg_acq), .miso (miso),
    .cs_n (cs_n), .sclk (sclk), .data_out (data_out), .valid (valid),
    .busy (busy), .proto_err (proto_err)
  );

  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;

  // converter stimulus
  int slv_pre = 0;
  int slv_pay = 0;

  // behavioural reference model state
  int m_t = -1;
  int m_H = 1, m_T = 16, m_A = 0, m_N = 12, m_pre = 0;
  logic [DATA_W-1:0] exp_data = '0;
  logic              exp_err  = 1'b0;

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s at cycle %0d: actual %0h expected %0h", req, cyc, act, expv);
    end
  endtask

  function automatic int nbits(input logic [1:0] s);
    if (s == 2'b00) return 12;
    if (s == 2'b01) return 10;
    return 8;
  endfunction

  // converter model: a new bit appears after each sclk falling edge
  int sk = 0;
  always @(negedge cs_n) sk = 0;
  always @(negedge sclk) begin
    if (!cs_n) begin
      if (sk < 4)            miso <= slv_pre[3-sk];
      else if (sk < m_T)     miso <= slv_pay[m_T-1-sk];
      else                   miso <= 1'b0;
      sk = sk + 1;
    end
  end

  // model timeline
  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (!rst_n) begin
      m_t <= -1; exp_data <= '0; exp_err <= 1'b0;
    end else if (m_t < 0) begin
      if (start) begin
        m_t   <= 0;
        m_H   <= (cfg_half == 0) ? 1 : int'(cfg_half);
        m_N   <= nbits(res_sel);
        m_T   <= 4 + nbits(res_sel);
        m_A   <= int'(cfg_acq);
        m_pre <= slv_pre;
      end
    end else if (m_t == (2*m_T+1)*m_H + m_A) begin
      m_t <= -1;
    end else begin
      m_t <= m_t + 1;
      if (m_t + 1 == (2*m_T+1)*m_H) begin
        exp_data <= DATA_W'(slv_pay & ((1 << m_N) - 1));
        exp_err  <= ((m_pre & 15) != 0);
      end
    end
  end

  // per-cycle comparison away from the active edge
  always @(negedge clk) begin
    int L;
    logic e_cs, e_sclk, e_busy, e_valid;
    L = (2*m_T+1)*m_H;
    if (!rst_n) begin
      chk(cs_n == 1'b1 && sclk == 1'b1, "R1", {cs_n, sclk}, 3);
      chk(valid == 1'b0 && busy == 1'b0 && proto_err == 1'b0 && data_out == '0,
          "R1", {valid, busy, proto_err}, 0);
    end else begin
      if (m_t < 0) begin
        e_cs = 1; e_sclk = 1; e_busy = 0; e_valid = 0;
      end else begin
        e_cs    = (m_t >= L);
        e_valid = (m_t == L);
        e_busy  = 1;
        if (m_t < m_H || m_t >= 2*m_T*m_H) e_sclk = 1;
        else e_sclk = (((m_t - m_H) / m_H) % 2) == 1;
      end
      chk(cs_n == e_cs, "R2/R5 cs_n", cs_n, e_cs);
      chk(sclk == e_sclk, "R2 sclk", sclk, e_sclk);
      chk(busy == e_busy, "R6/R7 busy", busy, e_busy);
      chk(valid == e_valid, "R5 valid", valid, e_valid);
      chk(data_out == exp_data, "R3 data_out", data_out, exp_data);
      if (m_t < 0 || m_t >= L)
        chk(proto_err == exp_err, "R8 proto_err", proto_err, exp_err);
    end
  end

  task automatic wait_idle();
    int k = 0;
    @(negedge clk);
    while (m_t >= 0 && k < 5000) begin @(negedge clk); k++; end
    repeat (2) @(negedge clk);
  endtask

  task automatic frame(input logic [1:0] rs, input int h, input int a,
                       input int pre, input int pay, input string req);
    int n;
    @(negedge clk);
    res_sel = rs; cfg_half = DIV_W'(h); cfg_acq = ACQ_W'(a);
    slv_pre = pre; slv_pay = pay;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    wait_idle();
    n = nbits(rs);
    chk(data_out == DATA_W'(pay & ((1 << n) - 1)), req, data_out, pay & ((1 << n) - 1));
  endtask

  // watchdog
  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: run did not complete");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);

    frame(2'b00, 1, 0, 0, 'hA5C, "R3 12-bit H1");
    frame(2'b01, 2, 3, 0, 'h2B7, "R4 10-bit H2");
    frame(2'b10, 3, 5, 0, 'hC3,  "R4 8-bit H3");
    frame(2'b11, 1, 0, 0, 'hF5A, "R4 sel11 8-bit");
    frame(2'b00, 0, 2, 0, 'hFFF, "R2 half zero acts as one");
    frame(2'b00, 2, 0, 0, 'h000, "R3 all zero");

    frame(2'b10, 1, 1, 4'b0100, 'h96, "R8 prefix error frame");
    chk(proto_err == 1'b1, "R8 flag set", proto_err, 1);
    repeat (6) @(negedge clk);
    chk(proto_err == 1'b1, "R8 flag held", proto_err, 1);
    frame(2'b10, 1, 1, 0, 'h69, "R8 clean frame");
    chk(proto_err == 1'b0, "R8 flag cleared", proto_err, 0);

    // R7: start held high over two frames, requests while busy ignored
    @(negedge clk);
    res_sel = 2'b01; cfg_half = 8'd1; cfg_acq = 16'd4;
    slv_pre = 0; slv_pay = 'h1E5;
    start = 1'b1;
    repeat (90) @(negedge clk);
    start = 1'b0;
    wait_idle();
    chk(data_out == 12'h1E5, "R7 back to back", data_out, 'h1E5);

    // R9: settings changed mid-frame do not affect the frame
    @(negedge clk);
    res_sel = 2'b00; cfg_half = 8'd2; cfg_acq = 16'd3;
    slv_pre = 0; slv_pay = 'h7C1;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    res_sel = 2'b10; cfg_half = 8'd5; cfg_acq = 16'd40;
    wait_idle();
    chk(data_out == 12'h7C1, "R9 latched settings", data_out, 'h7C1);

    repeat (4) @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule